// File: doc/BRIEF.md
# Status Register Transition Filter

This block is one 16-bit status group of an instrument's status reporting. Live fault and state flags enter on `cond_i` and are sampled once per clock. A programmable filter decides for each bit whether a rising change, a falling change, either, or neither is latched into a sticky event register. An enable mask selects which event bits drive a single registered summary output, which a higher level of the status hierarchy can collect. One filter and event setting covers the whole group, not each channel.

Software reaches the block through a small register port. Address 0 is the rising-edge filter, address 1 the falling-edge filter, address 2 the summary enable mask and address 3 the event register. A read of address 3 returns the events and clears them. A filter is handled as a level view of the condition: rewriting a filter can itself raise an event, exactly as if the condition bit had just changed. Bits 0 to 15 carry, in order: voltage fault, over-current, under-current, over-power, under-power, over-temperature, reverse current, sense-line fault, input undervoltage lockout, external inhibit, unregulated input, over-voltage, under-voltage, protection trip, oscillation and low voltage.

Top module: `stsreg_filter_top`

## Requirements
- R1: With the rising filter bit (address 0) set, a 0-to-1 change of that `cond_i` bit presented before clock edge k is visible in the event register after edge k+1.
- R2: With the falling filter bit (address 1) set, a 1-to-0 change of that `cond_i` bit sets the event bit with the same latency as R1.
- R3: With both filter bits of a position set, either change sets the event bit; with both clear, no change of that bit sets it.
- R4: Setting a rising filter bit while its condition bit is 1, or a falling filter bit while its condition bit is 0, sets that event bit one edge after the write; clearing a filter bit never sets an event.
- R5: Writes to the filters (addresses 0 and 1) cannot set bit 15, which reads back 0; the enable mask (address 2) keeps all 16 bits.
- R6: Event bits stay set until the event register is read.
- R7: A read of address 3 returns the event register on `rd_data_o` in the same cycle and clears it at the following edge, while any event arising at that edge is kept.
- R8: `summary_o` is high one edge after the event register ANDed with the enable mask is nonzero, and low one edge after it is zero.
- R9: Synchronous reset clears the condition history, both filters, the enable mask, the events and `summary_o`; a write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_i | input | 16 | Live condition flags |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address (0 rising filter, 1 falling filter, 2 enable) |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 2 | Read address (3 reads and clears the events) |
| rd_data_o | output | 16 | Read data, valid in the cycle of the read strobe, 0 otherwise |
| summary_o | output | 1 | Registered OR of enabled event bits |

## Verification
The clearing read of the event register and a newly detected transition can land on the same clock edge. The bench pre-loads one event bit, then drives a rising change on another bit so that its detection falls exactly on the edge that performs the clear. It judges the result by checking that the read returned only the old bit and that an immediate second read returns only the new bit.

// File: rtl/stsreg_pkg.sv
package stsreg_pkg;

    typedef enum logic [1:0] {
        ADDR_POS = 2'd0,
        ADDR_NEG = 2'd1,
        ADDR_ENA = 2'd2,
        ADDR_EVT = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/stsreg_cfg.sv
module stsreg_cfg
    import stsreg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en_i,
    input  logic [1:0]   wr_addr_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] pos_o,
    output logic [W-1:0] neg_o,
    output logic [W-1:0] ena_o
);

    // Filter writes are limited to W-1 bits; the top bit stays clear.
    localparam logic [W-1:0] FILT_WR_MASK = {1'b0, {(W-1){1'b1}}};

    typedef struct packed {
        logic [W-1:0] pos;
        logic [W-1:0] neg;
        logic [W-1:0] ena;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            case (wr_addr_i)
                ADDR_POS: cfg_d.pos = wr_data_i & FILT_WR_MASK;
                ADDR_NEG: cfg_d.neg = wr_data_i & FILT_WR_MASK;
                ADDR_ENA: cfg_d.ena = wr_data_i;
                default:  cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    assign pos_o = cfg_q.pos;
    assign neg_o = cfg_q.neg;
    assign ena_o = cfg_q.ena;

endmodule

// File: rtl/stsreg_edge.sv
module stsreg_edge #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cond_i,
    input  logic [W-1:0] pos_i,
    input  logic [W-1:0] neg_i,
    output logic [W-1:0] set_o
);

    // Each bit keeps two filtered level views: condition-high gated by the
    // rising filter and condition-low gated by the falling filter. A 0-to-1
    // step of either view is an event, whether the condition or the filter
    // moved.
    typedef struct packed {
        logic [W-1:0] cond;
        logic [W-1:0] pv;
        logic [W-1:0] nv;
    } hist_t;

    hist_t st_d, st_q;
    logic [W-1:0] pv_cur;
    logic [W-1:0] nv_cur;

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign pv_cur[b] =  st_q.cond[b] & pos_i[b];
        assign nv_cur[b] = ~st_q.cond[b] & neg_i[b];
        assign set_o[b]  = (pv_cur[b] & ~st_q.pv[b]) | (nv_cur[b] & ~st_q.nv[b]);
    end

    always_comb begin
        st_d      = st_q;
        st_d.cond = cond_i;
        st_d.pv   = pv_cur;
        st_d.nv   = nv_cur;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/stsreg_event.sv
module stsreg_event #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    input  logic [W-1:0] ena_i,
    output logic [W-1:0] evt_o,
    output logic         sum_o
);

    typedef struct packed {
        logic [W-1:0] evt;
        logic         sum;
    } evt_t;

    evt_t ev_d, ev_q;

    always_comb begin
        ev_d     = ev_q;
        // A clear drops only the bits that were read; new sets survive.
        ev_d.evt = (clr_i ? '0 : ev_q.evt) | set_i;
        ev_d.sum = |(ev_q.evt & ena_i);
    end

    always_ff @(posedge clk) begin
        if (rst) ev_q <= '0;
        else     ev_q <= ev_d;
    end

    assign evt_o = ev_q.evt;
    assign sum_o = ev_q.sum;

endmodule

// File: rtl/stsreg_filter_top.sv
module stsreg_filter_top
    import stsreg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cond_i,
    input  logic         wr_en_i,
    input  logic [1:0]   wr_addr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         rd_en_i,
    input  logic [1:0]   rd_addr_i,
    output logic [W-1:0] rd_data_o,
    output logic         summary_o
);

    logic [W-1:0] pos_vec;
    logic [W-1:0] neg_vec;
    logic [W-1:0] ena_vec;
    logic [W-1:0] set_vec;
    logic [W-1:0] evt_vec;
    logic         evt_clr;

    assign evt_clr = rd_en_i && (rd_addr_i == ADDR_EVT);

    stsreg_cfg #(.W(W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .pos_o     (pos_vec),
        .neg_o     (neg_vec),
        .ena_o     (ena_vec)
    );

    stsreg_edge #(.W(W)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .cond_i (cond_i),
        .pos_i  (pos_vec),
        .neg_i  (neg_vec),
        .set_o  (set_vec)
    );

    stsreg_event #(.W(W)) u_event (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_vec),
        .clr_i (evt_clr),
        .ena_i (ena_vec),
        .evt_o (evt_vec),
        .sum_o (summary_o)
    );

    always_comb begin
        rd_data_o = '0;
        if (rd_en_i) begin
            case (rd_addr_i)
                ADDR_POS: rd_data_o = pos_vec;
                ADDR_NEG: rd_data_o = neg_vec;
                ADDR_ENA: rd_data_o = ena_vec;
                default:  rd_data_o = evt_vec;
            endcase
        end
    end

endmodule

// File: rtl/stsreg_filter_chk.sv
module stsreg_filter_chk
    import stsreg_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         rd_en_i,
    input logic [1:0]   rd_addr_i,
    input logic [W-1:0] evt_q,
    input logic [W-1:0] pos_q,
    input logic [W-1:0] neg_q,
    input logic [W-1:0] ena_q,
    input logic         summary_o
);

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(rd_en_i && rd_addr_i == ADDR_EVT) |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R6

    AST_FILT_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (pos_q[W-1] == 1'b0) && (neg_q[W-1] == 1'b0)); // R5

    AST_SET_NEEDS_FILTER: assert property (@(posedge clk) disable iff (rst)
        ((evt_q & ~$past(evt_q) & ~$past(pos_q | neg_q)) == '0)); // R3

    AST_SUM_RISE: assert property (@(posedge clk) disable iff (rst)
        ((evt_q & ena_q) != '0) |=> summary_o); // R8

    AST_SUM_FALL: assert property (@(posedge clk) disable iff (rst)
        ((evt_q & ena_q) == '0) |=> !summary_o); // R8

endmodule

bind stsreg_filter_top stsreg_filter_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .evt_q     (evt_vec),
    .pos_q     (pos_vec),
    .neg_q     (neg_vec),
    .ena_q     (ena_vec),
    .summary_o (summary_o)
);

// File: tb/stsreg_filter_top_tb.sv
module stsreg_filter_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cond_i = '0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic        rd_en_i = 1'b0;
    logic [1:0]  rd_addr_i = '0;
    logic [15:0] rd_data_o;
    logic        summary_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    stsreg_filter_top #(.W(16)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .cond_i    (cond_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .summary_o (summary_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        tick(1);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        rd_en_i = 1'b1; rd_addr_i = a;
        #1 v = rd_data_o;
        tick(1);
        rd_en_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        rd(2'd0, v); check("R9 pos", v, 16'h0);
        rd(2'd1, v); check("R9 neg", v, 16'h0);
        rd(2'd2, v); check("R9 ena", v, 16'h0);
        rd(2'd3, v); check("R9 evt", v, 16'h0);
        check("R9 summary", {15'd0, summary_o}, 16'h0);
        wr(2'd3, 16'hFFFF); tick(2);
        rd(2'd3, v); check("R9 write to events ignored", v, 16'h0);

        // R5 filter top bit masked
        wr(2'd0, 16'hFFFF); rd(2'd0, v); check("R5 pos", v, 16'h7FFF);
        wr(2'd1, 16'hFFFF); rd(2'd1, v); check("R5 neg", v, 16'h7FFF);
        wr(2'd2, 16'hFFFF); rd(2'd2, v); check("R5 ena", v, 16'hFFFF);
        wr(2'd0, 16'h0); wr(2'd1, 16'h0); wr(2'd2, 16'h0);
        tick(3); rd(2'd3, v);

        // R4 filter rewrite generates events
        cond_i = 16'hFFFF; tick(3); rd(2'd3, v);
        wr(2'd0, 16'h00F0); tick(2);
        rd(2'd3, v); check("R4 rising filter on high cond", v, 16'h00F0);
        wr(2'd0, 16'h0); tick(2);
        rd(2'd3, v); check("R4 clearing filter", v, 16'h0);
        cond_i = 16'h0; tick(3); rd(2'd3, v);
        wr(2'd1, 16'h0F00); tick(2);
        rd(2'd3, v); check("R4 falling filter on low cond", v, 16'h0F00);
        wr(2'd1, 16'h0); tick(2);
        rd(2'd3, v); check("R4 clearing filter", v, 16'h0);

        // R1 R2 R3 R5 sweep over bit, filter combination and direction
        for (int i = 0; i < 16; i++) begin
            for (int c = 0; c < 4; c++) begin
                for (int d = 0; d < 2; d++) begin
                    logic [15:0] bm, exp;
                    string req;
                    bm = 16'h1 << i;
                    cond_i = (d == 1) ? bm : 16'h0;
                    tick(2);
                    wr(2'd0, c[0] ? bm : 16'h0);
                    wr(2'd1, c[1] ? bm : 16'h0);
                    tick(3);
                    rd(2'd3, v);
                    tick(1);
                    cond_i = (d == 1) ? 16'h0 : bm;
                    tick(3);
                    rd(2'd3, v);
                    exp = ((i < 15) && ((d == 0 && c[0]) || (d == 1 && c[1]))) ? bm : 16'h0;
                    if (i == 15)      req = "R5 top bit";
                    else if (c == 0 || c == 3) req = "R3";
                    else if (d == 0)  req = "R1";
                    else              req = "R2";
                    check(req, v, exp);
                end
            end
        end

        // R7 clear and new event on the same edge
        cond_i = 16'h0; tick(2);
        wr(2'd0, 16'h0003); wr(2'd1, 16'h0);
        tick(3); rd(2'd3, v);
        cond_i = 16'h0002; tick(3);
        cond_i = 16'h0003; tick(1);
        rd(2'd3, v); check("R7 read returns old events", v, 16'h0002);
        rd(2'd3, v); check("R7 same-edge event kept", v, 16'h0001);
        rd(2'd3, v); check("R7 cleared", v, 16'h0);

        // R8 summary timing and masking, R6 stickiness
        wr(2'd2, 16'h0001);
        cond_i = 16'h0002; tick(3); rd(2'd3, v); tick(2);
        check("R8 idle summary", {15'd0, summary_o}, 16'h0);
        cond_i = 16'h0003; tick(2);
        check("R8 summary one edge later", {15'd0, summary_o}, 16'h0);
        tick(1);
        check("R8 summary high", {15'd0, summary_o}, 16'h1);
        tick(10);
        rd(2'd3, v); check("R6 sticky", v, 16'h0001);
        tick(1);
        check("R8 summary low after clear", {15'd0, summary_o}, 16'h0);
        cond_i = 16'h0001; tick(3);
        cond_i = 16'h0003; tick(4);
        check("R8 masked bit", {15'd0, summary_o}, 16'h0);
        tick(8);
        rd(2'd3, v); check("R6 sticky masked", v, 16'h0002);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule